// File: doc/BRIEF.md
# Write-Cycle and Protect Controller

This block sits between the command decoder of a serial non-volatile memory and its storage. It decides when an internal programming cycle begins, holds a busy flag for a programmable number of clock cycles, and issues a one-cycle commit strobe when the cycle ends. A cycle starts only on the rising edge of the active-low chip select, and only if the decoder reports a complete, valid write sequence and the write-enable latch is set. Once a cycle has begun, it runs to completion whatever chip select or write protect do.

The block also holds the non-volatile status bits: two block-protect bits and a protect-enable bit. A status-register write is blocked when the active-low write-protect pin is asserted while protect-enable is set. Write protect is sampled only at the chip-select edge that would start the status write, and a blocked write is dropped at once. When protect-enable is clear, the pin has no effect. Writes to the array are never gated by the pin.

The status byte has this layout. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are block protect and bit 7 is protect enable. All other bits read as zero.

Top module: `wrcyc_ctrl`

## Requirements
- R1: A rising edge of `cs_n` seen at a clock edge while `wr_seq_ok` is high, the write-enable latch is set and the block is idle starts a cycle, and `busy` is high from that edge on.
- R2: `busy` stays high for exactly `cyc_len` clock cycles. A `cyc_len` of 0 is treated as 1.
- R3: While busy, chip-select activity and further valid write sequences neither stop nor restart the cycle. Its length is unchanged and only one commit strobe results.
- R4: `commit` is high for exactly one clock cycle, the first cycle in which `busy` is low after a cycle.
- R5: `wel_set` sets the write-enable latch (status bit 1) when idle. The latch clears when a cycle completes or a write is aborted.
- R6: A status write (`sr_wr` high) whose starting edge sees `wp_n` low and protect enable (bit 7) set is aborted. No busy and no commit follow, bits 7 and 3:2 are unchanged, and the latch is cleared.
- R7: With `wp_n` high, or with protect enable clear, a status write proceeds. After the commit, bit 7 and bits 3:2 equal bits 7 and 3:2 of `sr_din` captured at the starting edge.
- R8: `wp_n` falling after a status write cycle has started does not affect that write.
- R9: `standby` is high exactly when `cs_n` is high and the block is not busy.
- R10: An array write (`sr_wr` low) proceeds for every combination of `wp_n` and protect enable, and leaves bits 7 and 3:2 unchanged.
- R11: A `cs_n` rising edge without `wr_seq_ok`, or with the write-enable latch clear, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| wp_n | input | 1 | Active-low write-protect pin |
| wel_set | input | 1 | Write-enable command from the decoder |
| wr_seq_ok | input | 1 | Decoder flag: a complete, valid write sequence was received |
| sr_wr | input | 1 | Decoder flag: the pending write targets the status register |
| sr_din | input | 8 | New status value from the decoder |
| cyc_len | input | CNT_W | Programming cycle length in clock cycles |
| busy | output | 1 | Internal write cycle in progress |
| commit | output | 1 | One-cycle strobe at cycle completion |
| standby | output | 1 | Deselected and idle |
| sr_q | output | 8 | Status register contents |

## Verification
The bench sweeps cycle lengths from 0 to 6 and every pairing of pin level and protect-enable for both status and array writes. A design that counts one cycle off, or that lets a zero length stick busy high, shows a wrong busy width. Chip select is toggled and a valid sequence is re-presented in the middle of a cycle. A design that restarts or extends the cycle there gives a longer busy or a second commit. The pin is also dropped just after a status write has started. A design that samples protection late then loses the new protect bits. Bare chip-select edges with no valid sequence or no latch set must start nothing.

// File: rtl/wrcyc_ctrl.sv
module wrcyc_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wp_n,
  input  logic             wel_set,
  input  logic             wr_seq_ok,
  input  logic             sr_wr,
  input  logic [7:0]       sr_din,
  input  logic [CNT_W-1:0] cyc_len,
  output logic             busy,
  output logic             commit,
  output logic             standby,
  output logic [7:0]       sr_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             cs_q, wel, pen, pend_sr, pend_pen;
  logic [1:0]       bp, pend_bp;
  logic [CNT_W-1:0] cnt;

  wire cs_rise = cs_n & ~cs_q;
  wire req     = cs_rise & wr_seq_ok & wel & ~busy;
  wire locked  = sr_wr & pen & ~wp_n;
  wire start   = req & ~locked;
  wire abort   = req & locked;
  wire last    = (cnt == ONE);

  assign busy    = (cnt != '0);
  assign standby = cs_n & ~busy;
  assign sr_q    = {pen, 3'b000, bp, wel, busy};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= (cyc_len == '0) ? ONE : cyc_len;
    else if (busy)  cnt <= cnt - ONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_sr  <= 1'b0;
      pend_pen <= 1'b0;
      pend_bp  <= 2'b00;
    end else if (start) begin
      pend_sr  <= sr_wr;
      pend_pen <= sr_din[7];
      pend_bp  <= sr_din[3:2];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      commit <= 1'b0;
      pen    <= 1'b0;
      bp     <= 2'b00;
    end else begin
      commit <= last;
      if (last && pend_sr) begin
        pen <= pend_pen;
        bp  <= pend_bp;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                wel <= 1'b0;
    else if (last || abort)    wel <= 1'b0;
    else if (wel_set && !busy) wel <= 1'b1;

  // R1
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_q && wr_seq_ok && wel && !busy && !(sr_wr && pen && !wp_n)) |=> busy);

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != ONE) |=> (busy && cnt == $past(cnt) - ONE));

  // R4
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> commit);

  // R4
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!busy && !$past(commit)));

  // R5
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wel);

  // R6
  lock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_q && wr_seq_ok && wel && !busy && sr_wr && pen && !wp_n) |=> (!busy && !wel));

  // R7
  pen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pen) |-> commit);

  // R9
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !standby);

endmodule

// File: tb/tb_wrcyc_ctrl.sv
module tb_wrcyc_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1, wel_set = 1'b0, wr_seq_ok = 1'b0, sr_wr = 1'b0;
  logic [7:0] sr_din = 8'h00;
  logic [15:0] cyc_len = 16'd1;
  logic busy, commit, standby;
  logic [7:0] sr_q;
  int errors = 0, checks = 0;
  logic pen_m = 1'b0;
  logic [1:0] bp_m = 2'b00;

  always #4 clk = ~clk;

  wrcyc_ctrl #(.CNT_W(16)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_wel();
    @(negedge clk) wel_set = 1'b1;
    @(negedge clk) wel_set = 1'b0;
    chk("R5 latch set", sr_q[1], 1);
  endtask

  task automatic write_op(input int len, input logic sr, input logic [7:0] d,
                          input logic wp, input logic seq, input logic drop_wp,
                          input logic poke, output int width, output int com);
    @(negedge clk);
    cs_n = 1'b0; cyc_len = 16'(len); sr_wr = sr; sr_din = d; wp_n = wp; wr_seq_ok = seq;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    wr_seq_ok = 1'b0; sr_wr = 1'b0;
    if (drop_wp) wp_n = 1'b0;
    width = 0;
    while (busy && width < 100) begin
      width++;
      chk("R9 standby low while busy", standby, 0);
      chk("R4 no commit while busy", commit, 0);
      if (poke && width == 1) begin
        cs_n = 1'b0; wr_seq_ok = 1'b1;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) wr_seq_ok = 1'b0;
        width++;
      end else @(negedge clk);
    end
    com = commit;
    @(negedge clk);
    chk("R4 commit one cycle", commit, 0);
    wp_n = 1'b1;
  endtask

  initial begin
    int w, c, exp_len;
    logic prot;
    repeat (3) @(negedge clk);
    chk("R9 reset standby", standby, 1);
    chk("reset status", sr_q, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: no valid sequence, then no latch
    set_wel();
    write_op(3, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, w, c);
    chk("R11 no seq busy", w, 0);
    chk("R11 no seq commit", c, 0);
    chk("R11 latch kept", sr_q[1], 1);
    write_op(3, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, w, c);
    chk("R2 len 3", w, 3);
    write_op(3, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, w, c);
    chk("R11 no latch busy", w, 0);
    chk("R11 no latch commit", c, 0);

    // R1 R2 R4 R5 R10: array writes, all lengths and protect combos
    for (int pe = 0; pe < 2; pe++) begin
      set_wel();
      write_op(4, 1'b1, {pe[0], 7'b0001100}, 1'b1, 1'b1, 1'b0, 1'b0, w, c);
      pen_m = pe[0]; bp_m = 2'b11;
      chk("R7 pen set", sr_q[7], pen_m);
      for (int wp = 0; wp < 2; wp++)
        for (int len = 0; len < 7; len++) begin
          set_wel();
          write_op(len, 1'b0, 8'h00, wp[0], 1'b1, 1'b0, 1'b0, w, c);
          exp_len = (len == 0) ? 1 : len;
          chk("R1 R2 R10 busy width", w, exp_len);
          chk("R4 commit strobe", c, 1);
          chk("R5 latch cleared", sr_q[1], 0);
          chk("R10 status kept", {sr_q[7], sr_q[3:2]}, {pen_m, bp_m});
          chk("R9 standby idle", standby, 1);
        end
    end

    // R6 R7: status writes over every pin / enable combination
    for (int pe = 0; pe < 2; pe++)
      for (int wp = 0; wp < 2; wp++)
        for (int v = 0; v < 2; v++) begin
          set_wel();
          write_op(2, 1'b1, {pe[0], 7'b0001000}, 1'b1, 1'b1, 1'b0, 1'b0, w, c);
          pen_m = pe[0]; bp_m = 2'b10;
          set_wel();
          write_op(2, 1'b1, {v[0], 3'b0, 2'b01, 2'b0}, wp[0], 1'b1, 1'b0, 1'b0, w, c);
          prot = pen_m && !wp[0];
          if (!prot) begin pen_m = v[0]; bp_m = 2'b01; end
          chk(prot ? "R6 abort busy" : "R7 busy", w, prot ? 0 : 2);
          chk(prot ? "R6 abort commit" : "R7 commit", c, prot ? 0 : 1);
          chk(prot ? "R6 bits kept" : "R7 bits new", {sr_q[7], sr_q[3:2]}, {pen_m, bp_m});
          chk("R5 R6 latch cleared", sr_q[1], 0);
        end

    // R8: pin drops after the status write starts
    set_wel();
    write_op(3, 1'b1, 8'h88, 1'b1, 1'b1, 1'b0, 1'b0, w, c);
    set_wel();
    write_op(5, 1'b1, 8'h84, 1'b1, 1'b1, 1'b1, 1'b0, w, c);
    chk("R8 busy", w, 5);
    chk("R8 bits", {sr_q[7], sr_q[3:2]}, {1'b1, 2'b01});

    // R3: chip select toggles with a valid sequence mid-cycle
    for (int len = 3; len < 7; len++) begin
      set_wel();
      write_op(len, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, w, c);
      chk("R3 width unchanged", w, len);
      chk("R3 commit", c, 1);
      chk("R3 no second cycle", busy, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule